// File: doc/BRIEF.md
# Voltage channel command resolver

The resolver holds per-channel settings for a set of voltage channels and turns a request for one channel in one power state into a transaction descriptor. The descriptor gives the regulator slave address, the voltage register address, the command register address, the address the transaction must target, and the voltage-select byte for that state. Each channel carries a 5-bit configuration word. For each setting, a bit in that word says whether the channel uses its own value or falls back to the default channel's value. A separate enable bit redirects the transaction from the voltage register address to the command register address.

One channel, fixed when the design is elaborated, decodes its configuration word in a permuted bit order. On the default channel, software can set only the enable bit. Each channel also holds a 2-bit auto-transition field, and a code that the channel does not support is never stored. All settings are written and read back through a small register port addressed by channel and field code.

The request path is a three-state sequencer with states IDLE, EMIT and FAULT. Transition ACCEPT, a strobe for a channel that exists, enters EMIT. Transition REJECT, a strobe for a channel index beyond the implemented count, enters FAULT. Transition QUIET, a cycle with no strobe, returns to IDLE. Every state follows these three transitions, so requests can arrive back to back. EMIT drives the valid pulse and FAULT drives the error pulse.

Top module: `vchan_resolver`

## Requirements
- R1: After reset, every stored setting reads back as zero, and neither the valid nor the error output is high until a request is made. A channel whose configuration word is zero takes every setting from the default channel.
- R2: On a normal-layout channel, the configuration bits mean the following. Bit 0 selects the channel's own slave address. Bit 1 selects its own voltage register address. Bit 2 selects its own command register address. Bit 3 is the enable. Bit 4 selects its own command values. A clear bit selects the default channel's value.
- R3: On the channel named by PERM_CH, the configuration bits mean the following. Bit 0 selects the channel's own slave address. Bit 1 selects its own command values. Bit 2 selects its own voltage register address. Bit 3 selects its own command register address. Bit 4 is the enable.
- R4: On the default channel, a write to the configuration word stores only the enable bit, and every other configuration bit reads back as zero.
- R5: The command-value register holds four bytes: ON in bits 7:0, ONLP in bits 15:8, RET in bits 23:16 and OFF in bits 31:24. The request state codes are ON=0, ONLP=1, RET=2 and OFF=3, and the code selects which byte is output.
- R6: The descriptor's target address is the resolved command register address when the requesting channel's own enable bit is set. Otherwise it is the resolved voltage register address. The default channel's enable bit has no effect on other channels.
- R7: The auto-transition field uses the codes 0 = disabled, 1 = sleep, 2 = retention and 3 = off. A write of a code that the channel's AT_SUPPORT bit marks as unsupported leaves the field unchanged. Code 0 is always accepted.
- R8: The descriptor and a one-cycle valid pulse appear on the clock edge after the request strobe is sampled. Requests on consecutive cycles produce descriptors on consecutive cycles.
- R9: A request with a channel index at or above NUM_CH raises a one-cycle error pulse, and the valid output stays low in that cycle.
- R10: The register field codes are 0 = configuration, 1 = slave address, 2 = voltage register address, 3 = command register address, 4 = command values and 5 = auto-transition. Writes to channels at or above NUM_CH, and writes with other field codes, change nothing. Reads of such channels or codes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel written |
| wr_field | input | 3 | Field code written |
| wr_data | input | 4*VS_W | Write data, right-aligned |
| rd_ch | input | CH_W | Channel read |
| rd_field | input | 3 | Field code read |
| rd_data | output | 4*VS_W | Read data, combinational |
| req_valid | input | 1 | Request strobe |
| req_ch | input | CH_W | Requested channel |
| req_state | input | 2 | Requested power state |
| desc_valid | output | 1 | Descriptor valid pulse |
| req_err | output | 1 | Out-of-range request pulse |
| desc_ch | output | CH_W | Channel of the descriptor |
| desc_sa | output | SA_W | Resolved slave address |
| desc_vreg | output | RA_W | Resolved voltage register address |
| desc_creg | output | RA_W | Resolved command register address |
| desc_addr | output | RA_W | Register address the transaction targets |
| desc_vsel | output | VS_W | Voltage-select byte for the state |

## Verification
The bench builds the block with its default parameters. These give five channels, channel 0 as the default and channel 1 as the permuted one. With five channels, the 3-bit index leaves the values 5 to 7 free, so the bench can exercise out-of-range requests and writes. The default support mask leaves off unsupported on channel 2 and sleep unsupported on channel 3, so rejected auto-transition codes can be seen on readback. Writing the same configuration word to channel 1 and to channel 2 gives different descriptors, which shows the two layouts side by side.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

    localparam int CFG_W = 5;

    typedef struct packed {
        logic own_sa;
        logic own_vra;
        logic own_cra;
        logic cra_en;
        logic own_cmd;
    } chan_flags_t;

    localparam logic [2:0] FLD_CFG  = 3'd0;
    localparam logic [2:0] FLD_SA   = 3'd1;
    localparam logic [2:0] FLD_VRA  = 3'd2;
    localparam logic [2:0] FLD_CRA  = 3'd3;
    localparam logic [2:0] FLD_CMDV = 3'd4;
    localparam logic [2:0] FLD_AUTO = 3'd5;

    function automatic chan_flags_t decode_cfg(input logic [CFG_W-1:0] raw,
                                               input logic permuted);
        chan_flags_t f;
        f.own_sa = raw[0];
        if (permuted) begin
            f.own_cmd = raw[1];
            f.own_vra = raw[2];
            f.own_cra = raw[3];
            f.cra_en  = raw[4];
        end else begin
            f.own_vra = raw[1];
            f.own_cra = raw[2];
            f.cra_en  = raw[3];
            f.own_cmd = raw[4];
        end
        return f;
    endfunction

    function automatic logic [CFG_W-1:0] writable_mask(input logic is_default,
                                                       input logic permuted);
        if (!is_default)
            return {CFG_W{1'b1}};
        else if (permuted)
            return 5'b10000;
        else
            return 5'b01000;
    endfunction

endpackage

// File: rtl/vcr_reg_bank.sv
module vcr_reg_bank
    import vcr_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CH_W = 3,
    parameter int SA_W = 7,
    parameter int RA_W = 8,
    parameter int VS_W = 8,
    parameter int DEF_CH = 0,
    parameter int PERM_CH = 1,
    parameter logic [4*NUM_CH-1:0] AT_SUPPORT = '1,
    localparam int WD_W = 4*VS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CH_W-1:0]               wr_ch,
    input  logic [2:0]                    wr_field,
    input  logic [WD_W-1:0]               wr_data,
    input  logic [CH_W-1:0]               rd_ch,
    input  logic [2:0]                    rd_field,
    output logic [WD_W-1:0]               rd_data,
    output chan_flags_t [NUM_CH-1:0]      flags_o,
    output logic [NUM_CH-1:0][SA_W-1:0]   sa_o,
    output logic [NUM_CH-1:0][RA_W-1:0]   vra_o,
    output logic [NUM_CH-1:0][RA_W-1:0]   cra_o,
    output logic [NUM_CH-1:0][WD_W-1:0]   cmdv_o
);

    localparam logic [CH_W:0] NUM_CH_L = (CH_W+1)'(NUM_CH);

    logic [NUM_CH-1:0][CFG_W-1:0] cfg_all;
    logic [NUM_CH-1:0][1:0]       auto_all;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic IS_PERM = (i == PERM_CH);
        localparam logic IS_DEF  = (i == DEF_CH);
        localparam logic [CFG_W-1:0] WMASK = writable_mask(IS_DEF, IS_PERM);

        logic [CFG_W-1:0] cfg_q;
        logic [SA_W-1:0]  sa_q;
        logic [RA_W-1:0]  vra_q;
        logic [RA_W-1:0]  cra_q;
        logic [WD_W-1:0]  cmdv_q;
        logic [1:0]       auto_q;
        logic             hit;
        logic             auto_ok;

        assign hit     = wr_en && (wr_ch == CH_W'(i));
        assign auto_ok = (wr_data[1:0] == 2'd0) || AT_SUPPORT[4*i + int'(wr_data[1:0])];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q  <= '0;
                sa_q   <= '0;
                vra_q  <= '0;
                cra_q  <= '0;
                cmdv_q <= '0;
                auto_q <= '0;
            end else if (hit) begin
                case (wr_field)
                    FLD_CFG:  cfg_q  <= wr_data[CFG_W-1:0] & WMASK;
                    FLD_SA:   sa_q   <= wr_data[SA_W-1:0];
                    FLD_VRA:  vra_q  <= wr_data[RA_W-1:0];
                    FLD_CRA:  cra_q  <= wr_data[RA_W-1:0];
                    FLD_CMDV: cmdv_q <= wr_data;
                    FLD_AUTO: if (auto_ok) auto_q <= wr_data[1:0];
                    default:  ;
                endcase
            end
        end

        assign cfg_all[i]  = cfg_q;
        assign auto_all[i] = auto_q;
        assign flags_o[i]  = decode_cfg(cfg_q, IS_PERM);
        assign sa_o[i]     = sa_q;
        assign vra_o[i]    = vra_q;
        assign cra_o[i]    = cra_q;
        assign cmdv_o[i]   = cmdv_q;
    end

    always_comb begin
        rd_data = '0;
        if ({1'b0, rd_ch} < NUM_CH_L) begin
            case (rd_field)
                FLD_CFG:  rd_data = WD_W'(cfg_all[rd_ch]);
                FLD_SA:   rd_data = WD_W'(sa_o[rd_ch]);
                FLD_VRA:  rd_data = WD_W'(vra_o[rd_ch]);
                FLD_CRA:  rd_data = WD_W'(cra_o[rd_ch]);
                FLD_CMDV: rd_data = cmdv_o[rd_ch];
                FLD_AUTO: rd_data = WD_W'(auto_all[rd_ch]);
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/vcr_resolve.sv
module vcr_resolve
    import vcr_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CH_W = 3,
    parameter int SA_W = 7,
    parameter int RA_W = 8,
    parameter int VS_W = 8,
    parameter int DEF_CH = 0,
    localparam int WD_W = 4*VS_W
) (
    input  logic [CH_W-1:0]               req_ch,
    input  logic [1:0]                    req_state,
    input  chan_flags_t [NUM_CH-1:0]      flags_i,
    input  logic [NUM_CH-1:0][SA_W-1:0]   sa_i,
    input  logic [NUM_CH-1:0][RA_W-1:0]   vra_i,
    input  logic [NUM_CH-1:0][RA_W-1:0]   cra_i,
    input  logic [NUM_CH-1:0][WD_W-1:0]   cmdv_i,
    output logic                          in_range,
    output logic [SA_W-1:0]               res_sa,
    output logic [RA_W-1:0]               res_vra,
    output logic [RA_W-1:0]               res_cra,
    output logic [RA_W-1:0]               res_addr,
    output logic [VS_W-1:0]               res_vsel
);

    localparam logic [CH_W:0]   NUM_CH_L = (CH_W+1)'(NUM_CH);
    localparam logic [CH_W-1:0] DEF_IDX  = CH_W'(DEF_CH);

    logic [CH_W-1:0] eff_ch;
    chan_flags_t     fl;
    logic [WD_W-1:0] cmd_word;

    assign in_range = ({1'b0, req_ch} < NUM_CH_L);
    assign eff_ch   = in_range ? req_ch : DEF_IDX;
    assign fl       = flags_i[eff_ch];

    assign res_sa   = fl.own_sa  ? sa_i[eff_ch]  : sa_i[DEF_IDX];
    assign res_vra  = fl.own_vra ? vra_i[eff_ch] : vra_i[DEF_IDX];
    assign res_cra  = fl.own_cra ? cra_i[eff_ch] : cra_i[DEF_IDX];
    assign cmd_word = fl.own_cmd ? cmdv_i[eff_ch] : cmdv_i[DEF_IDX];
    assign res_addr = fl.cra_en  ? res_cra : res_vra;
    assign res_vsel = cmd_word[int'(req_state)*VS_W +: VS_W];

endmodule

// File: rtl/vcr_seq.sv
module vcr_seq #(
    parameter int CH_W = 3,
    parameter int SA_W = 7,
    parameter int RA_W = 8,
    parameter int VS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             in_range,
    input  logic [CH_W-1:0]  req_ch,
    input  logic [SA_W-1:0]  res_sa,
    input  logic [RA_W-1:0]  res_vra,
    input  logic [RA_W-1:0]  res_cra,
    input  logic [RA_W-1:0]  res_addr,
    input  logic [VS_W-1:0]  res_vsel,
    output logic             desc_valid,
    output logic             req_err,
    output logic [CH_W-1:0]  desc_ch,
    output logic [SA_W-1:0]  desc_sa,
    output logic [RA_W-1:0]  desc_vreg,
    output logic [RA_W-1:0]  desc_creg,
    output logic [RA_W-1:0]  desc_addr,
    output logic [VS_W-1:0]  desc_vsel
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    seq_state_e state_q, state_d;
    logic       accept;

    assign accept = req_valid && in_range;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_EMIT, ST_FAULT: begin
                if (accept)         state_d = ST_EMIT;
                else if (req_valid) state_d = ST_FAULT;
                else                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ch   <= '0;
            desc_sa   <= '0;
            desc_vreg <= '0;
            desc_creg <= '0;
            desc_addr <= '0;
            desc_vsel <= '0;
        end else if (accept) begin
            desc_ch   <= req_ch;
            desc_sa   <= res_sa;
            desc_vreg <= res_vra;
            desc_creg <= res_cra;
            desc_addr <= res_addr;
            desc_vsel <= res_vsel;
        end
    end

    always_comb begin
        desc_valid = 1'b0;
        req_err    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_EMIT:  desc_valid = 1'b1;
            ST_FAULT: req_err    = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/vchan_resolver.sv
module vchan_resolver
    import vcr_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int DEF_CH = 0,
    parameter int PERM_CH = 1,
    parameter int SA_W = 7,
    parameter int RA_W = 8,
    parameter int VS_W = 8,
    parameter logic [4*NUM_CH-1:0] AT_SUPPORT = 20'hFD7FF,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WD_W = 4*VS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [2:0]       wr_field,
    input  logic [WD_W-1:0]  wr_data,
    input  logic [CH_W-1:0]  rd_ch,
    input  logic [2:0]       rd_field,
    output logic [WD_W-1:0]  rd_data,
    input  logic             req_valid,
    input  logic [CH_W-1:0]  req_ch,
    input  logic [1:0]       req_state,
    output logic             desc_valid,
    output logic             req_err,
    output logic [CH_W-1:0]  desc_ch,
    output logic [SA_W-1:0]  desc_sa,
    output logic [RA_W-1:0]  desc_vreg,
    output logic [RA_W-1:0]  desc_creg,
    output logic [RA_W-1:0]  desc_addr,
    output logic [VS_W-1:0]  desc_vsel
);

    chan_flags_t [NUM_CH-1:0]    flags;
    logic [NUM_CH-1:0][SA_W-1:0] sa_all;
    logic [NUM_CH-1:0][RA_W-1:0] vra_all;
    logic [NUM_CH-1:0][RA_W-1:0] cra_all;
    logic [NUM_CH-1:0][WD_W-1:0] cmdv_all;

    logic            in_range;
    logic [SA_W-1:0] res_sa;
    logic [RA_W-1:0] res_vra;
    logic [RA_W-1:0] res_cra;
    logic [RA_W-1:0] res_addr;
    logic [VS_W-1:0] res_vsel;

    vcr_reg_bank #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .SA_W(SA_W), .RA_W(RA_W), .VS_W(VS_W),
        .DEF_CH(DEF_CH), .PERM_CH(PERM_CH), .AT_SUPPORT(AT_SUPPORT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_field(wr_field), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_field(rd_field), .rd_data(rd_data),
        .flags_o(flags), .sa_o(sa_all), .vra_o(vra_all), .cra_o(cra_all),
        .cmdv_o(cmdv_all)
    );

    vcr_resolve #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .SA_W(SA_W), .RA_W(RA_W), .VS_W(VS_W),
        .DEF_CH(DEF_CH)
    ) u_resolve (
        .req_ch(req_ch), .req_state(req_state),
        .flags_i(flags), .sa_i(sa_all), .vra_i(vra_all), .cra_i(cra_all),
        .cmdv_i(cmdv_all),
        .in_range(in_range), .res_sa(res_sa), .res_vra(res_vra),
        .res_cra(res_cra), .res_addr(res_addr), .res_vsel(res_vsel)
    );

    vcr_seq #(
        .CH_W(CH_W), .SA_W(SA_W), .RA_W(RA_W), .VS_W(VS_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .in_range(in_range), .req_ch(req_ch),
        .res_sa(res_sa), .res_vra(res_vra), .res_cra(res_cra),
        .res_addr(res_addr), .res_vsel(res_vsel),
        .desc_valid(desc_valid), .req_err(req_err), .desc_ch(desc_ch),
        .desc_sa(desc_sa), .desc_vreg(desc_vreg), .desc_creg(desc_creg),
        .desc_addr(desc_addr), .desc_vsel(desc_vsel)
    );

endmodule

// File: rtl/vchan_resolver_chk.sv
module vchan_resolver_chk
    import vcr_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CH_W = 3,
    parameter int DEF_CH = 0,
    parameter int PERM_CH = 1,
    parameter int RA_W = 8,
    parameter int WD_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [CH_W-1:0] req_ch,
    input logic [CH_W-1:0] rd_ch,
    input logic [2:0]      rd_field,
    input logic [WD_W-1:0] rd_data,
    input logic            desc_valid,
    input logic            req_err,
    input logic [RA_W-1:0] desc_vreg,
    input logic [RA_W-1:0] desc_creg,
    input logic [RA_W-1:0] desc_addr
);

    localparam logic [CH_W:0] NUM_CH_L = (CH_W+1)'(NUM_CH);
    localparam logic [WD_W-1:0] KEEP =
        WD_W'(writable_mask(1'b1, DEF_CH == PERM_CH));

    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_ch} < NUM_CH_L)) |=> desc_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!desc_valid && !req_err));

    a_r9_err_on_bad_ch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_ch} >= NUM_CH_L)) |=> (req_err && !desc_valid));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_valid, req_err}));

    a_r4_default_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ch == CH_W'(DEF_CH) && rd_field == FLD_CFG) |-> ((rd_data & ~KEEP) == '0));

    a_r6_target_pick: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_addr == desc_vreg || desc_addr == desc_creg));

endmodule

bind vchan_resolver vchan_resolver_chk #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DEF_CH(DEF_CH), .PERM_CH(PERM_CH),
    .RA_W(RA_W), .WD_W(WD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
    .rd_ch(rd_ch), .rd_field(rd_field), .rd_data(rd_data),
    .desc_valid(desc_valid), .req_err(req_err), .desc_vreg(desc_vreg),
    .desc_creg(desc_creg), .desc_addr(desc_addr)
);

// File: tb/vchan_resolver_test.sv
module vchan_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ch = '0;
    logic [2:0]  wr_field = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_ch = '0;
    logic [2:0]  rd_field = '0;
    logic [31:0] rd_data;
    logic        req_valid = 1'b0;
    logic [2:0]  req_ch = '0;
    logic [1:0]  req_state = '0;
    logic        desc_valid, req_err;
    logic [2:0]  desc_ch;
    logic [6:0]  desc_sa;
    logic [7:0]  desc_vreg, desc_creg, desc_addr, desc_vsel;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vchan_resolver uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_field(wr_field), .wr_data(wr_data), .rd_ch(rd_ch),
        .rd_field(rd_field), .rd_data(rd_data), .req_valid(req_valid),
        .req_ch(req_ch), .req_state(req_state), .desc_valid(desc_valid),
        .req_err(req_err), .desc_ch(desc_ch), .desc_sa(desc_sa),
        .desc_vreg(desc_vreg), .desc_creg(desc_creg), .desc_addr(desc_addr),
        .desc_vsel(desc_vsel)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int fld, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 3'(ch); wr_field = 3'(fld); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int ch, input int fld, input logic [31:0] exp);
        rd_ch = 3'(ch); rd_field = 3'(fld);
        #1;
        check(req, 64'(rd_data), 64'(exp));
    endtask

    // expects {sa, vreg, creg, addr, vsel}
    task automatic req_check(input string req, input int ch, input int st,
                             input logic [6:0] sa, input logic [7:0] vr,
                             input logic [7:0] cr, input logic [7:0] ad,
                             input logic [7:0] vs);
        @(negedge clk);
        req_valid = 1'b1; req_ch = 3'(ch); req_state = 2'(st);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 64'(desc_valid), 64'd1);
        check({req, " desc"}, {desc_sa, desc_vreg, desc_creg, desc_addr, desc_vsel},
              64'({sa, vr, cr, ad, vs}));
        @(negedge clk);
        check({req, " pulse"}, 64'(desc_valid), 64'd0);
    endtask

    task automatic t_reset;
        check("R1 valid idle", 64'(desc_valid), 64'd0);
        check("R1 err idle", 64'(req_err), 64'd0);
        for (int f = 0; f < 6; f++) rd_check("R1 reset readback", 2, f, 32'h0);
        req_check("R1 zero fallback", 2, 0, 7'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    endtask

    task automatic t_program;
        wr(0, 1, 32'h12); wr(0, 2, 32'h20); wr(0, 3, 32'h21); wr(0, 4, 32'h44332211);
        wr(2, 1, 32'h35); wr(2, 2, 32'h40); wr(2, 3, 32'h41); wr(2, 4, 32'h88776655);
        wr(1, 1, 32'h50); wr(1, 2, 32'h60); wr(1, 3, 32'h61); wr(1, 4, 32'hDDCCBBAA);
        wr(0, 0, 32'h1F);
        rd_check("R4 default cfg masked", 0, 0, 32'h08);
        rd_check("R10 cmdval readback", 2, 4, 32'h88776655);
    endtask

    task automatic t_normal;
        wr(2, 0, 32'h03);
        req_check("R2 own sa+vra", 2, 2, 7'h35, 8'h40, 8'h21, 8'h40, 8'h33);
        wr(2, 0, 32'h1C);
        req_check("R2 own cra+en+cmd", 2, 3, 7'h12, 8'h20, 8'h41, 8'h41, 8'h88);
    endtask

    task automatic t_perm;
        wr(1, 0, 32'h02);
        req_check("R3 perm own cmd", 1, 1, 7'h12, 8'h20, 8'h21, 8'h20, 8'hBB);
        wr(1, 0, 32'h1C);
        req_check("R3 perm vra+cra+en", 1, 1, 7'h12, 8'h60, 8'h61, 8'h61, 8'h22);
    endtask

    task automatic t_enable;
        req_check("R6 default en", 0, 0, 7'h12, 8'h20, 8'h21, 8'h21, 8'h11);
        req_check("R6 en not inherited", 3, 0, 7'h12, 8'h20, 8'h21, 8'h20, 8'h11);
        req_check("R5 ONLP byte", 0, 1, 7'h12, 8'h20, 8'h21, 8'h21, 8'h22);
    endtask

    task automatic t_auto;
        wr(2, 5, 32'h2); rd_check("R7 ch2 retention", 2, 5, 32'h2);
        wr(2, 5, 32'h3); rd_check("R7 ch2 off rejected", 2, 5, 32'h2);
        wr(2, 5, 32'h0); rd_check("R7 ch2 disable", 2, 5, 32'h0);
        wr(3, 5, 32'h1); rd_check("R7 ch3 sleep rejected", 3, 5, 32'h0);
        wr(3, 5, 32'h3); rd_check("R7 ch3 off", 3, 5, 32'h3);
        wr(4, 5, 32'h1); rd_check("R7 ch4 sleep", 4, 5, 32'h1);
    endtask

    task automatic t_bad_ch;
        @(negedge clk);
        req_valid = 1'b1; req_ch = 3'd6; req_state = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 err pulse", 64'(req_err), 64'd1);
        check("R9 no valid", 64'(desc_valid), 64'd0);
        @(negedge clk);
        check("R9 err one cycle", 64'(req_err), 64'd0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_ch = 3'd2; req_state = 2'd0;
        @(negedge clk);
        req_ch = 3'd1; req_state = 2'd3;
        check("R8 first valid", 64'(desc_valid), 64'd1);
        check("R8 first desc", {desc_ch, desc_addr, desc_vsel}, 64'({3'd2, 8'h41, 8'h55}));
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 second valid", 64'(desc_valid), 64'd1);
        check("R8 second desc", {desc_ch, desc_addr, desc_vsel}, 64'({3'd1, 8'h61, 8'h44}));
        @(negedge clk);
        check("R8 idle after", 64'(desc_valid), 64'd0);
    endtask

    task automatic t_ignored;
        wr(5, 1, 32'h7F);
        rd_check("R10 bad ch read", 5, 1, 32'h0);
        wr(2, 6, 32'hFFFF);
        rd_check("R10 bad field read", 2, 6, 32'h0);
        rd_check("R10 ch2 sa kept", 2, 1, 32'h35);
        rd_check("R10 ch0 sa kept", 0, 1, 32'h12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_program;
        t_normal;
        t_perm;
        t_enable;
        t_auto;
        t_bad_ch;
        t_back_to_back;
        t_ignored;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule